// File: doc/BRIEF.md
# Configurable Logic Cell Function Unit

This block is the back end of a configurable logic cell. It receives four already-formed gate signals and turns them into the cell output. A 3-bit mode field selects one of eight functions. Three functions are combinational. The other five hold state: an SR latch, two D flip-flop variants, a JK flip-flop and a transparent latch. Each function assigns the four gates to fixed roles such as clock, data, set, reset and latch enable.

The function result passes through an optional inversion and is then registered. That register is both the cell output and the status of the cell. A one-cycle interrupt pulse can be raised on a rising edge of the output, a falling edge, or both. A pin-drive enable tells the pad logic when the cell owns its pin.

The edge-triggered functions do not use g0 as a clock. Instead, g0 is sampled on the system clock, and a rising edge is a high g0 following a low sample. All behaviour is therefore synchronous to the system clock.

Top module: `logic_cell_core`

## Requirements
- R1: With `en_i`=1, the output register updates one clock edge after the gates are sampled. Gate k is `gate_i[k]`. The three combinational modes are:
  - mode 0: (g0&g1)|(g2&g3)
  - mode 1: (g0|g1)^(g2|g3)
  - mode 2: g0&g1&g2&g3
- R2: Mode 3 is an SR latch. Set is g0|g1 and reset is g2|g3. When set and reset are both active, set wins. With neither active, the latch holds.
- R3: Mode 4 is a D flip-flop.
  - Roles: clock g0, data g1, reset g2, set g3.
  - Priority: set over reset, and reset over a clock edge.
- R4: Mode 5 is a D flip-flop with clock g0, data g1|g3 and reset g2. Reset has priority over a clock edge.
- R5: Mode 6 is a JK flip-flop.
  - Roles: clock g0, J g1, K g3, reset g2. Reset has priority.
  - On a clock edge: J=K=1 toggles, J=1 K=0 sets, J=0 K=1 clears, and J=K=0 holds.
- R6: Mode 7 is a transparent latch.
  - Roles: reset g0, data g1, latch enable g2, set g3. Set has priority over reset.
  - With neither set nor reset active, the latch follows g1 while g2 is low and holds while g2 is high.
- R7: A clock edge is g0 high at a sampling edge after g0 was low at the previous sampling edge. Holding g0 high causes no further capture.
- R8: When `out_inv_i`=1, the function result is inverted before it reaches `out_o`.
- R9: `irq_o` pulses for one cycle, in the same cycle that `out_o` changes. It pulses on 0→1 when `irq_rise_en_i`=1 and on 1→0 when `irq_fall_en_i`=1.
- R10: `pin_oe_o` is combinationally `en_i & oe_i`. Clearing either input releases the pin.
- R11: While `en_i`=0, `out_o` holds and `irq_o` stays low. The stateful functions keep updating while disabled, and their state appears at the output once the cell is enabled again.
- R12: Reset (`rst_ni`=0) clears `out_o`, `irq_o`, the shared state bit and the g0 sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gate_i | input | 4 | Gate signals g0..g3 (bit k = gk) |
| mode_i | input | 3 | Function select 0..7 |
| en_i | input | 1 | Cell enable |
| oe_i | input | 1 | Pin output enable |
| irq_rise_en_i | input | 1 | Interrupt on output rising edge |
| irq_fall_en_i | input | 1 | Interrupt on output falling edge |
| out_inv_i | input | 1 | Output polarity invert |
| out_o | output | 1 | Registered cell output / status |
| irq_o | output | 1 | One-cycle interrupt pulse |
| pin_oe_o | output | 1 | Pin drive enable |

## Verification
A corrupted shared state bit or a stale g0 sample shows up at `out_o` on the very next clock edge. The wrong value then persists until a set, a reset or a fresh capture overwrites it, so each stateful test first forces a known value and then follows every edge it applies. Any interrupt fault surfaces as a missing or extra `irq_o` pulse in the same cycle as the output transition. The bench watches for that pulse and confirms it has cleared one cycle later.

// File: rtl/lcf_pkg.sv
package lcf_pkg;
  localparam int GATES  = 4;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_AND_OR = 3'd0,
    MODE_OR_XOR = 3'd1,
    MODE_AND4   = 3'd2,
    MODE_SR     = 3'd3,
    MODE_DFF_SR = 3'd4,
    MODE_DFF_OR = 3'd5,
    MODE_JK     = 3'd6,
    MODE_LATCH  = 3'd7
  } cell_mode_e;

  function automatic logic mode_has_state(cell_mode_e m);
    return (m == MODE_SR) || (m == MODE_DFF_SR) || (m == MODE_DFF_OR) ||
           (m == MODE_JK) || (m == MODE_LATCH);
  endfunction
endpackage

// File: rtl/lcf_edge_det.sv
module lcf_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/lcf_comb_fn.sv
module lcf_comb_fn
  import lcf_pkg::*;
(
  input  cell_mode_e       mode_i,
  input  logic [GATES-1:0] gate_i,
  output logic             res_o
);
  always_comb begin
    unique case (mode_i)
      MODE_AND_OR: res_o = (gate_i[0] & gate_i[1]) | (gate_i[2] & gate_i[3]);
      MODE_OR_XOR: res_o = (gate_i[0] | gate_i[1]) ^ (gate_i[2] | gate_i[3]);
      MODE_AND4:   res_o = &gate_i;
      default:     res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lcf_state_fn.sv
module lcf_state_fn
  import lcf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cell_mode_e       mode_i,
  input  logic [GATES-1:0] gate_i,
  input  logic             rise_i,
  output logic             next_o
);
  logic state_q;
  logic set_c, rst_c;

  always_comb begin
    next_o = state_q;
    set_c  = 1'b0;
    rst_c  = 1'b0;
    unique case (mode_i)
      MODE_SR: begin
        set_c = gate_i[0] | gate_i[1];
        rst_c = gate_i[2] | gate_i[3];
        if (set_c)      next_o = 1'b1;
        else if (rst_c) next_o = 1'b0;
      end
      MODE_DFF_SR: begin
        if (gate_i[3])      next_o = 1'b1;
        else if (gate_i[2]) next_o = 1'b0;
        else if (rise_i)    next_o = gate_i[1];
      end
      MODE_DFF_OR: begin
        if (gate_i[2])   next_o = 1'b0;
        else if (rise_i) next_o = gate_i[1] | gate_i[3];
      end
      MODE_JK: begin
        if (gate_i[2]) next_o = 1'b0;
        else if (rise_i) begin
          unique case ({gate_i[1], gate_i[3]})
            2'b11:   next_o = ~state_q;
            2'b10:   next_o = 1'b1;
            2'b01:   next_o = 1'b0;
            default: next_o = state_q;
          endcase
        end
      end
      MODE_LATCH: begin
        if (gate_i[3])       next_o = 1'b1;
        else if (gate_i[0])  next_o = 1'b0;
        else if (!gate_i[2]) next_o = gate_i[1];
      end
      default: next_o = state_q;
    endcase
  end

  // state advances regardless of cell enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= 1'b0;
    else         state_q <= next_o;
  end
endmodule

// File: rtl/lcf_out_stage.sv
module lcf_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic res_i,
  input  logic inv_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  output logic out_o,
  output logic irq_o
);
  logic out_q, irq_q, new_c;

  assign new_c = res_i ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= en_i & ((~out_q & new_c & rise_en_i) | (out_q & ~new_c & fall_en_i));
      if (en_i) out_q <= new_c;
    end
  end

  assign out_o = out_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/logic_cell_core.sv
module logic_cell_core
  import lcf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GATES-1:0]  gate_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              en_i,
  input  logic              oe_i,
  input  logic              irq_rise_en_i,
  input  logic              irq_fall_en_i,
  input  logic              out_inv_i,
  output logic              out_o,
  output logic              irq_o,
  output logic              pin_oe_o
);
  cell_mode_e mode;
  logic rise, comb_res, seq_res, res;

  assign mode = cell_mode_e'(mode_i);

  lcf_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (gate_i[0]),
    .rise_o(rise)
  );

  lcf_comb_fn u_comb (
    .mode_i(mode),
    .gate_i(gate_i),
    .res_o (comb_res)
  );

  lcf_state_fn u_state (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode),
    .gate_i(gate_i),
    .rise_i(rise),
    .next_o(seq_res)
  );

  assign res = mode_has_state(mode) ? seq_res : comb_res;

  lcf_out_stage u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .res_i    (res),
    .inv_i    (out_inv_i),
    .rise_en_i(irq_rise_en_i),
    .fall_en_i(irq_fall_en_i),
    .out_o    (out_o),
    .irq_o    (irq_o)
  );

  assign pin_oe_o = en_i & oe_i;
endmodule

// File: rtl/lcf_checker.sv
module lcf_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] gate_i,
  input logic [2:0] mode_i,
  input logic       en_i,
  input logic       oe_i,
  input logic       irq_rise_en_i,
  input logic       irq_fall_en_i,
  input logic       out_inv_i,
  input logic       out_o,
  input logic       irq_o,
  input logic       pin_oe_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r10_pin_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && oe_i) |-> !pin_oe_o);

  a_r9_irq_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && irq_o) |-> (out_o != $past(out_o)));

  a_r9_rise_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && irq_o && out_o) |-> $past(irq_rise_en_i));

  a_r9_fall_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && irq_o && !out_o) |-> $past(irq_fall_en_i));

  a_r11_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(en_i)) |-> ($stable(out_o) && !irq_o));

  a_r1_and4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(en_i && mode_i == 3'd2 && !out_inv_i)) |-> (out_o == &$past(gate_i)));

  a_r2_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(en_i && mode_i == 3'd3 && !out_inv_i && (gate_i[0] || gate_i[1]))) |-> out_o);

  a_r3_set_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(en_i && mode_i == 3'd4 && !out_inv_i && gate_i[3])) |-> out_o);
endmodule

bind logic_cell_core lcf_checker u_chk (.*);

// File: tb/tb_logic_cell_core.sv
`timescale 1ns/1ps
module tb_logic_cell_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] gate_i = '0;
  logic [2:0] mode_i = '0;
  logic       en_i = 1'b0, oe_i = 1'b0;
  logic       irq_rise_en_i = 1'b0, irq_fall_en_i = 1'b0, out_inv_i = 1'b0;
  logic       out_o, irq_o, pin_oe_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  logic_cell_core dut (.*);

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic apply(logic [2:0] m, logic [3:0] g);
    mode_i = m; gate_i = g; step();
  endtask

  task automatic t_reset();
    chk("R12 out", out_o, 1'b0);
    chk("R12 irq", irq_o, 1'b0);
    chk("R10 pin at reset", pin_oe_o, 1'b0);
  endtask

  task automatic t_comb();
    logic e;
    en_i = 1'b1;
    for (int m = 0; m < 3; m++) begin
      for (int v = 0; v < 16; v++) begin
        logic [3:0] g;
        g = v[3:0];
        apply(m[2:0], g);
        if (m == 0)      e = (g[0] & g[1]) | (g[2] & g[3]);
        else if (m == 1) e = (g[0] | g[1]) ^ (g[2] | g[3]);
        else             e = &g;
        chk("R1 comb", out_o, e);
      end
    end
  endtask

  task automatic t_sr();
    apply(3'd3, 4'b0001); chk("R2 set g0", out_o, 1'b1);
    apply(3'd3, 4'b0000); chk("R2 hold", out_o, 1'b1);
    apply(3'd3, 4'b0100); chk("R2 reset g2", out_o, 1'b0);
    apply(3'd3, 4'b1010); chk("R2 set wins", out_o, 1'b1);
    apply(3'd3, 4'b1000); chk("R2 reset g3", out_o, 1'b0);
  endtask

  task automatic t_dff();
    apply(3'd4, 4'b0100); chk("R3 reset", out_o, 1'b0);
    apply(3'd4, 4'b0010); chk("R3 no edge", out_o, 1'b0);
    apply(3'd4, 4'b0011); chk("R3 capture 1", out_o, 1'b1);
    apply(3'd4, 4'b0001); chk("R7 g0 held high", out_o, 1'b1);
    apply(3'd4, 4'b0000); chk("R3 g0 low", out_o, 1'b1);
    apply(3'd4, 4'b0001); chk("R3 capture 0", out_o, 1'b0);
    apply(3'd4, 4'b1000); chk("R3 set", out_o, 1'b1);
    apply(3'd4, 4'b1100); chk("R3 set over reset", out_o, 1'b1);
    apply(3'd4, 4'b0100); chk("R3 reset", out_o, 1'b0);
    apply(3'd4, 4'b0000);
    apply(3'd4, 4'b0111); chk("R3 reset over edge", out_o, 1'b0);
  endtask

  task automatic t_dff2();
    apply(3'd5, 4'b0100); chk("R4 reset", out_o, 1'b0);
    apply(3'd5, 4'b1000); chk("R4 no edge", out_o, 1'b0);
    apply(3'd5, 4'b1001); chk("R4 capture g3", out_o, 1'b1);
    apply(3'd5, 4'b0000);
    apply(3'd5, 4'b0001); chk("R4 capture 0", out_o, 1'b0);
    apply(3'd5, 4'b0000);
    apply(3'd5, 4'b0011); chk("R4 capture g1", out_o, 1'b1);
    apply(3'd5, 4'b0000);
    apply(3'd5, 4'b0111); chk("R4 reset over edge", out_o, 1'b0);
  endtask

  task automatic t_jk();
    apply(3'd6, 4'b0100); chk("R5 reset", out_o, 1'b0);
    apply(3'd6, 4'b0000);
    apply(3'd6, 4'b0011); chk("R5 J set", out_o, 1'b1);
    apply(3'd6, 4'b0000);
    apply(3'd6, 4'b0001); chk("R5 hold", out_o, 1'b1);
    apply(3'd6, 4'b0000);
    apply(3'd6, 4'b1011); chk("R5 toggle to 0", out_o, 1'b0);
    apply(3'd6, 4'b1010); chk("R7 no re-toggle", out_o, 1'b0);
    apply(3'd6, 4'b1011); chk("R5 toggle to 1", out_o, 1'b1);
    apply(3'd6, 4'b0000);
    apply(3'd6, 4'b1001); chk("R5 K clear", out_o, 1'b0);
  endtask

  task automatic t_latch();
    apply(3'd7, 4'b1000); chk("R6 set", out_o, 1'b1);
    apply(3'd7, 4'b0001); chk("R6 reset", out_o, 1'b0);
    apply(3'd7, 4'b1001); chk("R6 set over reset", out_o, 1'b1);
    apply(3'd7, 4'b0010); chk("R6 follow 1", out_o, 1'b1);
    apply(3'd7, 4'b0000); chk("R6 follow 0", out_o, 1'b0);
    apply(3'd7, 4'b0110); chk("R6 closed hold", out_o, 1'b0);
    apply(3'd7, 4'b0010); chk("R6 reopen", out_o, 1'b1);
    apply(3'd7, 4'b0100); chk("R6 closed hold 1", out_o, 1'b1);
  endtask

  task automatic t_pol();
    out_inv_i = 1'b1;
    apply(3'd2, 4'b1111); chk("R8 invert and", out_o, 1'b0);
    apply(3'd2, 4'b0000); chk("R8 invert and 0", out_o, 1'b1);
    out_inv_i = 1'b0;
    apply(3'd2, 4'b0000); chk("R8 no invert", out_o, 1'b0);
  endtask

  task automatic t_irq();
    irq_rise_en_i = 1'b1; irq_fall_en_i = 1'b0;
    apply(3'd2, 4'b0000); step();
    apply(3'd2, 4'b1111); chk("R9 rise out", out_o, 1'b1); chk("R9 rise irq", irq_o, 1'b1);
    step();               chk("R9 pulse one cycle", irq_o, 1'b0);
    apply(3'd2, 4'b0000); chk("R9 fall masked", irq_o, 1'b0);
    irq_rise_en_i = 1'b0; irq_fall_en_i = 1'b1;
    apply(3'd2, 4'b1111); chk("R9 rise masked", irq_o, 1'b0);
    apply(3'd2, 4'b0000); chk("R9 fall irq", irq_o, 1'b1);
    step();               chk("R9 fall pulse ends", irq_o, 1'b0);
  endtask

  task automatic t_pin();
    for (int k = 0; k < 4; k++) begin
      en_i = k[0]; oe_i = k[1]; #1;
      chk("R10 pin", pin_oe_o, k[0] & k[1]);
    end
    en_i = 1'b1; oe_i = 1'b0;
  endtask

  task automatic t_disable();
    irq_rise_en_i = 1'b1; irq_fall_en_i = 1'b1; en_i = 1'b1;
    apply(3'd2, 4'b1111); chk("R11 pre", out_o, 1'b1);
    en_i = 1'b0;
    apply(3'd2, 4'b0000); chk("R11 hold", out_o, 1'b1); chk("R11 no irq", irq_o, 1'b0);
    apply(3'd4, 4'b0100); chk("R11 hold stateful", out_o, 1'b1);
    apply(3'd4, 4'b0000);
    en_i = 1'b1; step();
    chk("R11 state shown", out_o, 1'b0); chk("R11 irq on enable", irq_o, 1'b1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    step();
    t_comb();
    t_sr();
    t_dff();
    t_dff2();
    t_jk();
    t_latch();
    t_pol();
    t_irq();
    t_pin();
    t_disable();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule